// File: doc/BRIEF.md
# I2C Target Register Expander

This block is an I2C target that holds one 8-bit register and drives it onto a parallel output port, so a bus controller can use it as an output expander. It runs on a fast system clock, many times faster than the 100 kHz standard-mode bus, and treats SCL and SDA as ordinary asynchronous inputs. SDA is open-drain: the block reads the line level and has a single enable that pulls the line low. SCL is input only, because the target never stretches the clock.

Each bus line first passes through a two-flop synchroniser and then a short history shift register. The filtered level flips only when every older sample in the history agrees. If they disagree, the previous level is held. Slow or noisy edges therefore settle before the rest of the logic sees them. START, STOP and the SCL rising and falling edges are all derived from the filtered levels, never from the raw pins.

After a START, the target collects the address byte and the read/write bit. It acknowledges only its own 7-bit address and otherwise stays silent until the next START. A write stores every data byte and acknowledges it. A read returns the stored byte, MSB first, for as long as the controller acknowledges.

Top module: `i2cx_reg_expander`

## Requirements
- R1: While reset is asserted and right after it is released, the SDA pull-down enable is 0 and the register output is 8'h00.
- R2: A pulse of at most two fast clocks on SCL or SDA is filtered out. A fake SCL edge or a fake START/STOP of that length does not change the result of the transfer.
- R3: When the 7 address bits (first byte, MSB first, bit 0 = read/write, 1 = read) equal the configured address, the target pulls SDA low during the high phase of the ninth clock.
- R4: When the address does not match, the target never drives SDA, and the rest of that transfer leaves the register unchanged.
- R5: In a write, each 8-bit data byte (MSB first) is copied to the register output and acknowledged with SDA low during the ninth clock. The register changes only at that point.
- R6: A read that follows a write returns exactly the byte last written, MSB first.
- R7: The SDA enable changes only while filtered SCL is low. The level the controller sees stays constant through each SCL high phase.
- R8: A NACK from the controller (SDA high in the ninth clock of a read byte) makes the target release SDA for every later clock until the next START.
- R9: An ACK from the controller (SDA low in the ninth clock of a read byte) makes the target send the register byte again.
- R10: A START in the middle of a byte aborts the transfer without storing anything and begins a new address phase.
- R11: A STOP in the middle of a byte aborts the transfer without storing anything and releases SDA.
- R12: Several data bytes in one write transfer are each acknowledged and stored in turn, so the register ends up holding the last one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | SCL line level, asynchronous |
| sda_i | input | 1 | SDA line level, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| gpio_o | output | 8 | Stored register value |

## Verification
The main write-then-read path is run with a table of data bytes that covers all zeros, all ones, alternating bits and a walking one and a walking zero. These patterns separate a wrong bit order, a stuck bit and an off-by-one shift count. Directed transfers then cover the other cases:
- a wrong address, which separates matching from blind acknowledging;
- multi-byte writes and multi-byte reads that end with a controller NACK;
- a START and a STOP in the middle of a byte;
- a write with injected two-clock glitches on both lines, which separates a voting filter from a plain synchroniser.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BITCNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/i2cx_line_filter.sv
module i2cx_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HIST_DEPTH  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);

  localparam int unsigned VOTE_W = HIST_DEPTH - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_DEPTH-1:0]  hist_q, hist_d;
  logic                   filt_q, filt_d;
  logic [VOTE_W-1:0]      vote;

  // Synchroniser chain, reset to the idle bus level
  generate
    genvar s;
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign vote = hist_q[HIST_DEPTH-1:1];

  always_comb begin
    hist_d = {hist_q[HIST_DEPTH-2:0], sync_q[SYNC_STAGES-1]};
    filt_d = filt_q;
    if (&vote)      filt_d = 1'b1;
    else if (~|vote) filt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      hist_q <= hist_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/i2cx_bus_events.sv
module i2cx_bus_events
  import i2cx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_f,
  input  logic     sda_f,
  output bus_evt_t evt_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    evt_o.scl_rise = scl_f & ~scl_q;
    evt_o.scl_fall = ~scl_f & scl_q;
    evt_o.start    = scl_f & scl_q & sda_q & ~sda_f;
    evt_o.stop     = scl_f & scl_q & ~sda_q & sda_f;
  end

endmodule

// File: rtl/i2cx_target_fsm.sv
module i2cx_target_fsm
  import i2cx_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt_i,
  input  logic              sda_f,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] hold_o
);

  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

  tgt_state_e          st_q, st_d;
  logic [BITCNT_W-1:0] cnt_q, cnt_d;
  logic [BYTE_W-1:0]   rx_q, rx_d;
  logic [BYTE_W-1:0]   tx_q, tx_d;
  logic [BYTE_W-1:0]   hold_q, hold_d;
  logic                oe_q, oe_d;
  logic                mack_q, mack_d;
  logic                byte_end;

  assign byte_end = evt_i.scl_fall && (cnt_q == LAST_BIT);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    hold_d = hold_q;
    oe_d   = oe_q;
    mack_d = mack_q;
    if (evt_i.stop) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (evt_i.start) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (evt_i.scl_rise) begin
            rx_d  = {rx_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + 1'b1;
          end else if (byte_end) begin
            if (rx_q[BYTE_W-1:1] == OWN_ADDR) begin
              oe_d = 1'b1;
              st_d = ST_ADDR_ACK;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (evt_i.scl_fall) begin
            cnt_d = '0;
            if (rx_q[0]) begin
              tx_d = hold_q;
              oe_d = ~hold_q[BYTE_W-1];
              st_d = ST_RD;
            end else begin
              oe_d = 1'b0;
              st_d = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (evt_i.scl_rise) begin
            rx_d  = {rx_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + 1'b1;
          end else if (byte_end) begin
            hold_d = rx_q;
            oe_d   = 1'b1;
            st_d   = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (evt_i.scl_fall) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            st_d  = ST_WR;
          end
        end
        ST_RD: begin
          if (evt_i.scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (byte_end) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            st_d  = ST_RD_ACK;
          end else if (evt_i.scl_fall) begin
            tx_d = {tx_q[BYTE_W-2:0], tx_q[BYTE_W-1]};
            oe_d = ~tx_q[BYTE_W-2];
          end
        end
        ST_RD_ACK: begin
          if (evt_i.scl_rise) begin
            mack_d = ~sda_f;
          end else if (evt_i.scl_fall) begin
            if (mack_q) begin
              tx_d  = hold_q;
              oe_d  = ~hold_q[BYTE_W-1];
              cnt_d = '0;
              st_d  = ST_RD;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      hold_q <= '0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      hold_q <= hold_d;
      oe_q   <= oe_d;
      mack_q <= mack_d;
    end
  end

  assign sda_oe_o = oe_q;
  assign hold_o   = hold_q;

endmodule

// File: rtl/i2cx_reg_expander.sv
module i2cx_reg_expander
  import i2cx_pkg::*;
#(
  parameter logic [6:0]  OWN_ADDR    = 7'h2A,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HIST_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] gpio_o
);

  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, filt_lines;
  logic               scl_f, sda_f;
  logic               start_evt, stop_evt;
  bus_evt_t           evt;

  assign raw_lines = {sda_i, scl_i};

  generate
    genvar l;
    for (l = 0; l < N_LINES; l++) begin : g_line
      i2cx_line_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .HIST_DEPTH (HIST_DEPTH)
      ) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw_lines[l]),
        .filt_o(filt_lines[l])
      );
    end
  endgenerate

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  i2cx_bus_events u_evt (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_f(scl_f),
    .sda_f(sda_f),
    .evt_o(evt)
  );

  assign start_evt = evt.start;
  assign stop_evt  = evt.stop;

  i2cx_target_fsm #(
    .OWN_ADDR(OWN_ADDR)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt),
    .sda_f   (sda_f),
    .sda_oe_o(sda_oe_o),
    .hold_o  (gpio_o)
  );

endmodule

// File: rtl/i2cx_reg_expander_chk.sv
module i2cx_reg_expander_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       sda_oe_o,
  input logic [7:0] gpio_o
);

  // R1: quiet outputs while held in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!sda_oe_o && gpio_o == 8'h00)
        else $error("a_r1_reset_quiet");
    end
  end

  // R7: no change of the drive enable inside a filtered SCL high phase
  a_r7_oe_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe_o));

  // R5: the register only moves together with the target's ACK
  a_r5_store_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpio_o) |-> sda_oe_o);

  // R10: a START leaves SDA released
  a_r10_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe_o);

  // R11: a STOP leaves SDA released
  a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe_o);

endmodule

bind i2cx_reg_expander i2cx_reg_expander_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .sda_oe_o (sda_oe_o),
  .gpio_o   (gpio_o)
);

// File: tb/i2cx_reg_expander_tb.sv
`timescale 1ns/1ps
module i2cx_reg_expander_tb;

  localparam logic [6:0] ADDR  = 7'h2A;
  localparam int         Q     = 12;
  localparam int         NVEC  = 12;
  localparam logic [7:0] VEC [NVEC] = '{
    8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80,
    8'hFE, 8'h7F, 8'h3C, 8'hC3, 8'h96, 8'h69
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_oe;
  logic [7:0] gpio;
  wire        sda_line = sda_m & ~sda_oe;

  int n_chk  = 0;
  int n_fail = 0;
  int stab_err = 0;
  logic watch = 1'b0;
  logic saw_drive = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  i2cx_reg_expander #(.OWN_ADDR(ADDR)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_line),
    .sda_oe_o(sda_oe),
    .gpio_o  (gpio)
  );

  always @(negedge clk) if (watch && sda_oe) saw_drive = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(2*Q);
  endtask

  // one clock; g injects two-clock glitches on SCL (low phase) and SDA (high phase)
  task automatic bit_x(input logic b, input logic g, output logic r);
    sda_m = b;
    if (g) begin
      wt(4); scl_m = 1'b1; wt(2); scl_m = 1'b0; wt(Q-6);
    end else wt(Q);
    scl_m = 1'b1;
    wt(4);
    r = sda_line;
    if (g) begin sda_m = ~b; wt(2); sda_m = b; end
    else wt(2);
    wt(2*Q-10);
    if (sda_line !== r) stab_err++;
    wt(4);
    scl_m = 1'b0;
  endtask

  task automatic byte_w(input logic [7:0] d, input int gbit, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(d[i], (i == gbit), r);
    bit_x(1'b1, 1'b0, ack);
  endtask

  task automatic byte_r(input logic nack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, 1'b0, r);
      d[i] = r;
    end
    bit_x(nack, 1'b0, r);
  endtask

  task automatic write1(input logic [6:0] a, input logic [7:0] d, input int gbit,
                        output logic aa, output logic ad);
    bus_start();
    byte_w({a, 1'b0}, -1, aa);
    byte_w(d, gbit, ad);
    bus_stop();
  endtask

  task automatic read1(input logic [6:0] a, output logic aa, output logic [7:0] d);
    bus_start();
    byte_w({a, 1'b1}, -1, aa);
    byte_r(1'b1, d);
    bus_stop();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic aa, ad, r;
    logic [7:0] d, d2;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    wt(5);
    chk("R1 oe in reset", sda_oe, 1'b0);
    chk("R1 gpio in reset", gpio, 8'h00);
    rst_n = 1'b1;
    wt(20);
    chk("R1 oe after reset", sda_oe, 1'b0);
    chk("R1 gpio after reset", gpio, 8'h00);

    // table-driven write then read
    for (int v = 0; v < NVEC; v++) begin
      write1(ADDR, VEC[v], -1, aa, ad);
      chk("R3 write addr ack", aa, 1'b0);
      chk("R5 data ack", ad, 1'b0);
      chk("R5 gpio", gpio, VEC[v]);
      read1(ADDR, aa, d);
      chk("R3 read addr ack", aa, 1'b0);
      chk("R6 readback", d, VEC[v]);
      chk("R8 released after nack", sda_oe, 1'b0);
    end

    // R4 wrong address
    watch = 1'b1; saw_drive = 1'b0;
    write1(ADDR ^ 7'h01, 8'h12, -1, aa, ad);
    watch = 1'b0;
    chk("R4 no addr ack", aa, 1'b1);
    chk("R4 no drive", saw_drive, 1'b0);
    chk("R4 gpio kept", gpio, 8'h69);

    // R12 multi-byte write
    bus_start();
    byte_w({ADDR, 1'b0}, -1, aa);
    byte_w(8'hA5, -1, ad);
    chk("R12 first byte ack", ad, 1'b0);
    chk("R12 first byte stored", gpio, 8'hA5);
    byte_w(8'h5A, -1, ad);
    chk("R12 second byte ack", ad, 1'b0);
    bus_stop();
    chk("R12 last byte kept", gpio, 8'h5A);

    // R9 / R8 multi-byte read, then extra clocks after NACK
    bus_start();
    byte_w({ADDR, 1'b1}, -1, aa);
    byte_r(1'b0, d);
    chk("R9 first read byte", d, 8'h5A);
    byte_r(1'b1, d2);
    chk("R9 repeated read byte", d2, 8'h5A);
    watch = 1'b1; saw_drive = 1'b0;
    for (int i = 0; i < 9; i++) bit_x(1'b1, 1'b0, r);
    watch = 1'b0;
    chk("R8 no drive after nack", saw_drive, 1'b0);
    bus_stop();

    // R10 START in the middle of a data byte
    bus_start();
    byte_w({ADDR, 1'b0}, -1, aa);
    for (int i = 0; i < 4; i++) bit_x(i[0], 1'b0, r);
    bus_start();
    byte_w({ADDR, 1'b1}, -1, aa);
    chk("R10 new address acked", aa, 1'b0);
    byte_r(1'b1, d);
    bus_stop();
    chk("R10 nothing stored", gpio, 8'h5A);
    chk("R10 read after abort", d, 8'h5A);

    // R11 STOP in the middle of a data byte
    bus_start();
    byte_w({ADDR, 1'b0}, -1, aa);
    for (int i = 0; i < 5; i++) bit_x(1'b0, 1'b0, r);
    bus_stop();
    chk("R11 nothing stored", gpio, 8'h5A);
    chk("R11 released", sda_oe, 1'b0);

    // R2 glitches on both lines inside a data byte
    write1(ADDR, 8'hC6, 3, aa, ad);
    chk("R2 addr ack with glitches", aa, 1'b0);
    chk("R2 data ack with glitches", ad, 1'b0);
    chk("R2 gpio with glitches", gpio, 8'hC6);
    write1(ADDR, 8'h39, 6, aa, ad);
    chk("R2 second glitched write", gpio, 8'h39);

    chk("R7 line stable in SCL high", stab_err, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule